// File: doc/BRIEF.md
# AXI-to-memory burst splitter

This block takes one AXI read or write address transaction and turns it into a series of memory burst commands. The transaction is split at the byte level. Its byte range becomes a run of memory words, where a word is as wide as the effective external data width. That run is then cut at memory-burst boundaries. Each command names the byte address of an aligned memory burst and carries a per-beat mask that marks which beats of that burst the transaction uses. Incrementing transactions become one run of commands. Wrapping transactions become two incrementing runs. Fixed transactions become one run per AXI beat, and every run covers the same bytes.

The address side accepts one transaction at a time. `a_ready` stays low from acceptance until the final command of that transaction has been handed over, so the upstream holds the next request. The command side is valid/ready. While `cmd_valid` is high and `cmd_ready` is low, the command fields are held. A command counts as issued only in a cycle where both are high. The two configuration pins are plain level inputs. They are sampled once, when a transaction is accepted.

Top module: `mem_burst_splitter`

## Requirements
- R1: `a_ready` is 1 whenever no transaction is held. From the cycle after an accepting edge, it stays 0 until the edge at which the command flagged last is taken. It is 1 again in the following cycle. `a_valid` and the address fields have no effect while `a_ready` is 0.
- R2: While `cmd_valid` is 1 and `cmd_ready` is 0, the values of `cmd_valid`, `cmd_addr`, `cmd_mask` and `cmd_last` do not change at the next edge.
- R3: A memory word is MEM_DW/8 bytes, or half that when `cfg_half_width` is 1. A memory burst is 4 words when `cfg_bl8` is 0 and 8 words when it is 1. Both pins are sampled at acceptance.
- R4: Burst code 1 (incrementing) covers the bytes from `a_addr` up to (`a_addr` rounded down to 2^`a_size`) + (`a_len`+1)·2^`a_size` − 1. One command is issued per memory burst that this range touches, in ascending order. `cmd_addr` is the byte address of the burst's first word. `cmd_mask` bit i is 1 when word i of that burst (bit 0 = lowest address) is touched.
- R5: Every `cmd_mask` is nonzero and is a single contiguous run of ones. In 4-word mode, bits 7:4 are 0.
- R6: Burst code 2 (wrapping) uses a container of (`a_len`+1)·2^`a_size` bytes, aligned to its own size. The block issues the commands for the bytes from `a_addr` to the container's top, and then the commands for the bytes from the container base to `a_addr` − 1. The second part is omitted when `a_addr` equals the base.
- R7: Burst code 0 (fixed) issues `a_len`+1 identical command runs. Each run covers the bytes from `a_addr` up to (`a_addr` rounded down to 2^`a_size`) + 2^`a_size` − 1.
- R8: `cmd_last` is 1 on the final command of a transaction and 0 on every other command.
- R9: Burst code 3 is handled exactly like code 1.
- R10: `cmd_valid` is 1 in the cycle after acceptance. It stays 1 until the last command is taken, so with `cmd_ready` held at 1 the block issues one command per cycle.
- R11: During and directly after reset, `a_ready` is 1 and `cmd_valid` is 0.
- R12: Changing `cfg_half_width` or `cfg_bl8` after acceptance has no effect on the commands of the transaction already accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_half_width | input | 1 | 1: memory word is half of MEM_DW |
| cfg_bl8 | input | 1 | 1: 8-word memory bursts, 0: 4-word |
| a_valid | input | 1 | Address transaction offered |
| a_ready | output | 1 | Block can take a transaction |
| a_addr | input | ADDR_W | Transaction start byte address |
| a_len | input | LEN_W | Beats minus one |
| a_size | input | 3 | Log2 of bytes per AXI beat |
| a_burst | input | 2 | 0 fixed, 1 incrementing, 2 wrapping, 3 as 1 |
| cmd_valid | output | 1 | Command offered |
| cmd_ready | input | 1 | Consumer takes the command |
| cmd_addr | output | ADDR_W | Byte address of the memory burst |
| cmd_mask | output | 8 | Words of the burst in use |
| cmd_last | output | 1 | Final command of the transaction |

## Verification
The hardest case to reach is a wrapping transaction whose second part starts partway through a memory burst. The same applies when that second part shares a burst with the end of the first part. Here the mask logic must restart at the container base, and it does so while the command side is being throttled. The stimulus sweeps every legal start offset within every container for each size, length, word width and burst length. It applies pseudo-random back-pressure and flips the configuration pins right after acceptance. Fixed and unaligned incrementing transactions are swept over sixteen byte offsets under the same four configurations.

// File: rtl/mbs_pkg.sv
package mbs_pkg;
  typedef enum logic [1:0] {
    BT_FIXED = 2'd0,
    BT_INCR  = 2'd1,
    BT_WRAP  = 2'd2,
    BT_RSVD  = 2'd3
  } burst_e;

  localparam int MASK_W   = 8;
  localparam int OFF_W    = 3;
  localparam int SIZE_W   = 3;
  localparam int BURST_W  = 2;
endpackage

// File: rtl/mbs_range.sv
// Turns the address-channel fields into one byte range ("piece") and the
// number of pieces the transaction needs.
module mbs_range #(
  parameter int ADDR_W  = 32,
  parameter int LEN_W   = 8,
  parameter int PIECE_W = LEN_W + 1
) (
  input  logic [ADDR_W-1:0]          addr,
  input  logic [LEN_W-1:0]           len,
  input  logic [mbs_pkg::SIZE_W-1:0] size,
  input  mbs_pkg::burst_e            burst,
  input  logic                       second,
  output logic [ADDR_W-1:0]          lo,
  output logic [ADDR_W-1:0]          hi,
  output logic [PIECE_W-1:0]         npieces
);
  import mbs_pkg::*;

  logic [ADDR_W-1:0] beat_bytes;
  logic [ADDR_W-1:0] aligned;
  logic [ADDR_W-1:0] span;
  logic [ADDR_W-1:0] wrap_base;

  always_comb begin
    beat_bytes = {{(ADDR_W-1){1'b0}}, 1'b1} << size;
    aligned    = addr & ~(beat_bytes - 1'b1);
    span       = (ADDR_W'(len) + 1'b1) << size;
    wrap_base  = addr & ~(span - 1'b1);
  end

  always_comb begin
    unique case (burst)
      BT_FIXED: begin
        lo      = addr;
        hi      = aligned + beat_bytes - 1'b1;
        npieces = PIECE_W'(len) + 1'b1;
      end
      BT_WRAP: begin
        if (!second) begin
          lo = addr;
          hi = wrap_base + span - 1'b1;
        end else begin
          lo = wrap_base;
          hi = addr - 1'b1;
        end
        npieces = (addr == wrap_base) ? PIECE_W'(1) : PIECE_W'(2);
      end
      default: begin
        lo      = addr;
        hi      = aligned + span - 1'b1;
        npieces = PIECE_W'(1);
      end
    endcase
  end
endmodule

// File: rtl/mbs_walker.sv
// Walks a word range burst by burst; holds the current and final word index.
module mbs_walker #(
  parameter int ADDR_W = 32
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       load,
  input  logic [ADDR_W-1:0]          lo_w,
  input  logic [ADDR_W-1:0]          hi_w,
  input  logic                       step,
  input  logic                       bl8,
  output logic [ADDR_W-1:0]          base_w,
  output logic [mbs_pkg::MASK_W-1:0] mask,
  output logic                       final_burst
);
  import mbs_pkg::*;

  logic [ADDR_W-1:0] cur_w;
  logic [ADDR_W-1:0] end_w;
  logic [ADDR_W-1:0] bl_m1;
  logic [OFF_W-1:0]  first_off;
  logic [OFF_W-1:0]  last_off;

  always_comb begin
    bl_m1       = bl8 ? ADDR_W'(7) : ADDR_W'(3);
    base_w      = cur_w & ~bl_m1;
    final_burst = (end_w & ~bl_m1) == base_w;
    first_off   = cur_w[OFF_W-1:0] & bl_m1[OFF_W-1:0];
    last_off    = final_burst ? (end_w[OFF_W-1:0] & bl_m1[OFF_W-1:0])
                              : bl_m1[OFF_W-1:0];
  end

  for (genvar i = 0; i < MASK_W; i++) begin : g_mask
    assign mask[i] = (OFF_W'(i) >= first_off) && (OFF_W'(i) <= last_off);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_w <= '0;
      end_w <= '0;
    end else if (load) begin
      cur_w <= lo_w;
      end_w <= hi_w;
    end else if (step) begin
      cur_w <= base_w + bl_m1 + 1'b1;
    end
  end
endmodule

// File: rtl/mem_burst_splitter.sv
module mem_burst_splitter #(
  parameter int ADDR_W = 32,
  parameter int AXI_DW = 64,
  parameter int MEM_DW = 32,
  parameter int LEN_W  = 8
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         cfg_half_width,
  input  logic                         cfg_bl8,
  input  logic                         a_valid,
  output logic                         a_ready,
  input  logic [ADDR_W-1:0]            a_addr,
  input  logic [LEN_W-1:0]             a_len,
  input  logic [mbs_pkg::SIZE_W-1:0]   a_size,
  input  logic [mbs_pkg::BURST_W-1:0]  a_burst,
  output logic                         cmd_valid,
  input  logic                         cmd_ready,
  output logic [ADDR_W-1:0]            cmd_addr,
  output logic [mbs_pkg::MASK_W-1:0]   cmd_mask,
  output logic                         cmd_last
);
  import mbs_pkg::*;

  localparam int PIECE_W = LEN_W + 1;
  localparam int MEM_LOG = $clog2(MEM_DW / 8);
  localparam logic [2:0] MLOG_FULL = 3'(MEM_LOG);

  if (MEM_DW > AXI_DW || MEM_DW < 16 ||
      (AXI_DW != 32 && AXI_DW != 64 && AXI_DW != 128)) begin : g_bad_cfg
    $error("mem_burst_splitter: unsupported data width parameters");
  end

  logic                  busy;
  logic [ADDR_W-1:0]     t_addr;
  logic [LEN_W-1:0]      t_len;
  logic [SIZE_W-1:0]     t_size;
  burst_e                t_burst;
  logic                  t_half;
  logic                  t_bl8;
  logic [PIECE_W-1:0]    pieces_left;

  logic                  accept;
  logic                  fire;
  logic                  last_piece;
  logic                  piece_done;

  logic [ADDR_W-1:0]     src_addr;
  logic [LEN_W-1:0]      src_len;
  logic [SIZE_W-1:0]     src_size;
  burst_e                src_burst;
  logic [2:0]            src_mlog;
  logic [2:0]            t_mlog;
  logic                  walk_bl8;

  logic [ADDR_W-1:0]     rg_lo;
  logic [ADDR_W-1:0]     rg_hi;
  logic [PIECE_W-1:0]    rg_npieces;

  logic                  wk_load;
  logic                  wk_step;
  logic [ADDR_W-1:0]     wk_base_w;
  logic [MASK_W-1:0]     wk_mask;
  logic                  wk_final;

  // Handshake terms
  always_comb begin
    accept     = a_valid && !busy;
    fire       = busy && cmd_ready;
    last_piece = pieces_left == '0;
    piece_done = fire && wk_final;
  end

  // Range source: the live inputs at acceptance, the held copy afterwards.
  always_comb begin
    t_mlog = MLOG_FULL - {2'b00, t_half};
    if (accept) begin
      src_addr  = a_addr;
      src_len   = a_len;
      src_size  = a_size;
      src_burst = burst_e'(a_burst);
      src_mlog  = MLOG_FULL - {2'b00, cfg_half_width};
      walk_bl8  = cfg_bl8;
    end else begin
      src_addr  = t_addr;
      src_len   = t_len;
      src_size  = t_size;
      src_burst = t_burst;
      src_mlog  = t_mlog;
      walk_bl8  = t_bl8;
    end
  end

  mbs_range #(
    .ADDR_W (ADDR_W),
    .LEN_W  (LEN_W),
    .PIECE_W(PIECE_W)
  ) u_range (
    .addr   (src_addr),
    .len    (src_len),
    .size   (src_size),
    .burst  (src_burst),
    .second (!accept),
    .lo     (rg_lo),
    .hi     (rg_hi),
    .npieces(rg_npieces)
  );

  always_comb begin
    wk_load = accept || (piece_done && !last_piece);
    wk_step = fire && !wk_final;
  end

  mbs_walker #(
    .ADDR_W(ADDR_W)
  ) u_walker (
    .clk        (clk),
    .rst_n      (rst_n),
    .load       (wk_load),
    .lo_w       (rg_lo >> src_mlog),
    .hi_w       (rg_hi >> src_mlog),
    .step       (wk_step),
    .bl8        (walk_bl8),
    .base_w     (wk_base_w),
    .mask       (wk_mask),
    .final_burst(wk_final)
  );

  // Transaction hold and piece bookkeeping
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy        <= 1'b0;
      t_addr      <= '0;
      t_len       <= '0;
      t_size      <= '0;
      t_burst     <= BT_INCR;
      t_half      <= 1'b0;
      t_bl8       <= 1'b0;
      pieces_left <= '0;
    end else if (accept) begin
      busy        <= 1'b1;
      t_addr      <= a_addr;
      t_len       <= a_len;
      t_size      <= a_size;
      t_burst     <= burst_e'(a_burst);
      t_half      <= cfg_half_width;
      t_bl8       <= cfg_bl8;
      pieces_left <= rg_npieces - 1'b1;
    end else if (piece_done) begin
      if (last_piece) begin
        busy <= 1'b0;
      end else begin
        pieces_left <= pieces_left - 1'b1;
      end
    end
  end

  always_comb begin
    a_ready   = !busy;
    cmd_valid = busy;
    cmd_addr  = wk_base_w << t_mlog;
    cmd_mask  = wk_mask;
    cmd_last  = last_piece && wk_final;
  end
endmodule

// File: rtl/mbs_checker.sv
module mbs_checker #(
  parameter int ADDR_W = 32,
  parameter int MEM_DW = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cfg_half_width,
  input logic              cfg_bl8,
  input logic              a_valid,
  input logic              a_ready,
  input logic              cmd_valid,
  input logic              cmd_ready,
  input logic [ADDR_W-1:0] cmd_addr,
  input logic [7:0]        cmd_mask,
  input logic              cmd_last
);
  localparam int MEM_LOG = $clog2(MEM_DW / 8);

  logic              seen_bl8;
  logic              seen_half;
  logic [ADDR_W-1:0] burst_m1;
  logic [8:0]        m9;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seen_bl8  <= 1'b0;
      seen_half <= 1'b0;
    end else if (a_valid && a_ready) begin
      seen_bl8  <= cfg_bl8;
      seen_half <= cfg_half_width;
    end
  end

  always_comb begin
    burst_m1 = ((seen_bl8 ? ADDR_W'(8) : ADDR_W'(4))
                << (MEM_LOG - (seen_half ? 1 : 0))) - 1'b1;
    m9 = {1'b0, cmd_mask};
  end

  assert_ready_low_R1: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |-> !a_ready);

  assert_release_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_ready && cmd_last) |=> (a_ready && !cmd_valid));

  assert_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !cmd_ready) |=> (cmd_valid && $stable(cmd_addr)
                                   && $stable(cmd_mask) && $stable(cmd_last)));

  assert_bl4_mask_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !seen_bl8) |-> (cmd_mask[7:4] == 4'h0));

  assert_aligned_R4: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |-> ((cmd_addr & burst_m1) == '0));

  assert_contig_R5: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |-> ((cmd_mask != 8'h00) && (((m9 + (m9 & (~m9 + 9'd1))) & m9) == 9'd0)));

  assert_start_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (a_valid && a_ready) |=> cmd_valid);

  assert_continue_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !(cmd_ready && cmd_last)) |=> cmd_valid);
endmodule

bind mem_burst_splitter mbs_checker #(
  .ADDR_W(ADDR_W),
  .MEM_DW(MEM_DW)
) u_checker (
  .clk           (clk),
  .rst_n         (rst_n),
  .cfg_half_width(cfg_half_width),
  .cfg_bl8       (cfg_bl8),
  .a_valid       (a_valid),
  .a_ready       (a_ready),
  .cmd_valid     (cmd_valid),
  .cmd_ready     (cmd_ready),
  .cmd_addr      (cmd_addr),
  .cmd_mask      (cmd_mask),
  .cmd_last      (cmd_last)
);

// File: tb/tb_mem_burst_splitter.sv
module tb_mem_burst_splitter;
  localparam int ADDR_W  = 32;
  localparam int AXI_DW  = 64;
  localparam int MEM_DW  = 32;
  localparam int LEN_W   = 8;
  localparam int MEM_LOG = 2;

  logic              clk = 1'b0;
  logic              rst_n;
  logic              cfg_half_width, cfg_bl8;
  logic              a_valid, a_ready;
  logic [ADDR_W-1:0] a_addr;
  logic [LEN_W-1:0]  a_len;
  logic [2:0]        a_size;
  logic [1:0]        a_burst;
  logic              cmd_valid, cmd_ready;
  logic [ADDR_W-1:0] cmd_addr;
  logic [7:0]        cmd_mask;
  logic              cmd_last;

  int n_chk = 0;
  int n_fail = 0;
  int txn_no = 0;
  logic [15:0] lfsr = 16'hACE1;

  longint    exp_addr[$];
  logic [7:0] exp_mask[$];

  always #5 clk = ~clk;

  mem_burst_splitter #(
    .ADDR_W(ADDR_W), .AXI_DW(AXI_DW), .MEM_DW(MEM_DW), .LEN_W(LEN_W)
  ) dut (
    .clk(clk), .rst_n(rst_n),
    .cfg_half_width(cfg_half_width), .cfg_bl8(cfg_bl8),
    .a_valid(a_valid), .a_ready(a_ready), .a_addr(a_addr), .a_len(a_len),
    .a_size(a_size), .a_burst(a_burst),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_addr(cmd_addr),
    .cmd_mask(cmd_mask), .cmd_last(cmd_last)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s txn %0d: actual 0x%0h expected 0x%0h", req, txn_no, act, expv);
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  task automatic add_range(input longint lo, input longint hi, input int mlog, input int bl);
    longint prev = -1;
    for (longint w = lo >> mlog; w <= (hi >> mlog); w++) begin
      longint b = w / bl;
      if (b != prev) begin
        exp_addr.push_back((b * bl) << mlog);
        exp_mask.push_back(8'h00);
        prev = b;
      end
      exp_mask[exp_mask.size()-1] = exp_mask[exp_mask.size()-1] | 8'(1 << (w % bl));
    end
  endtask

  task automatic build_exp(input longint addr, input int len, input int size,
                           input int burst, input bit half, input bit bl8);
    longint sz   = longint'(1) << size;
    longint al   = addr & ~(sz - 1);
    longint span = longint'(len + 1) * sz;
    int     mlog = MEM_LOG - (half ? 1 : 0);
    int     bl   = bl8 ? 8 : 4;
    exp_addr.delete();
    exp_mask.delete();
    if (burst == 0) begin
      for (int r = 0; r <= len; r++) add_range(addr, al + sz - 1, mlog, bl);
    end else if (burst == 2) begin
      longint base = (addr / span) * span;
      add_range(addr, base + span - 1, mlog, bl);
      if (addr != base) add_range(base, addr - 1, mlog, bl);
    end else begin
      add_range(addr, al + span - 1, mlog, bl);
    end
  endtask

  task automatic run_txn(input longint addr, input int len, input int size,
                         input int burst, input bit half, input bit bl8);
    string  tag;
    int     idx = 0;
    bit     done = 0;
    bit     bp = (txn_no % 3) != 0;
    bit     flip = (txn_no % 2) == 1;
    bit     junk = (txn_no % 4) == 1;
    bit     stalled = 0;
    int     fails_before = n_fail;
    int     guard = 0;
    longint s_addr = 0;
    logic [7:0] s_mask = 0;
    logic   s_last = 0;
    logic [8:0] m9;

    tag = (burst == 0) ? "R7" : (burst == 2) ? "R6" : (burst == 3) ? "R9" : "R4";
    build_exp(addr, len, size, burst, half, bl8);

    cfg_half_width = half;
    cfg_bl8        = bl8;
    a_addr  = addr[ADDR_W-1:0];
    a_len   = LEN_W'(len);
    a_size  = 3'(size);
    a_burst = 2'(burst);
    a_valid = 1'b1;
    while (!a_ready && guard < 20) begin
      @(negedge clk);
      guard++;
    end
    @(negedge clk);
    // accepted at the edge just passed
    a_valid = junk;
    if (junk) begin
      a_addr  = 32'h0000_7F00;
      a_len   = 8'd9;
      a_burst = 2'd0;
    end
    if (flip) begin
      cfg_half_width = ~half;
      cfg_bl8        = ~bl8;
    end
    chk(cmd_valid === 1'b1, "R10 first command", cmd_valid, 1);
    guard = 0;
    while (!done && guard < 1000) begin
      guard++;
      if (cmd_valid !== 1'b1) begin
        chk(0, "R10 valid dropped", cmd_valid, 1);
        break;
      end
      chk(a_ready === 1'b0, "R1 ready low while busy", a_ready, 0);
      if (stalled) begin
        chk(cmd_addr == s_addr[ADDR_W-1:0] && cmd_mask == s_mask && cmd_last == s_last,
            "R2 hold under back-pressure", cmd_addr, s_addr);
      end
      m9 = {1'b0, cmd_mask};
      chk(cmd_mask != 0 && (((m9 + (m9 & (~m9 + 9'd1))) & m9) == 0),
          "R5 contiguous mask", cmd_mask, 0);
      if (!bl8) chk(cmd_mask[7:4] == 4'h0, "R3 four-word mask", cmd_mask, cmd_mask & 8'h0F);
      cmd_ready = bp ? lfsr[0] : 1'b1;
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      if (cmd_ready) begin
        stalled = 0;
        if (idx >= exp_addr.size()) begin
          chk(0, "R8 extra command", idx, exp_addr.size());
          break;
        end
        chk(longint'(cmd_addr) == exp_addr[idx], {tag, " R3 burst address"}, cmd_addr, exp_addr[idx]);
        chk(cmd_mask == exp_mask[idx], {tag, " R3 beat mask"}, cmd_mask, exp_mask[idx]);
        chk(cmd_last == (idx == exp_addr.size() - 1), "R8 last flag", cmd_last,
            (idx == exp_addr.size() - 1) ? 1 : 0);
        idx++;
        if (cmd_last) begin
          a_valid = 1'b0;
          done = 1;
        end
      end else begin
        stalled = 1;
        s_addr  = longint'(cmd_addr);
        s_mask  = cmd_mask;
        s_last  = cmd_last;
      end
      @(negedge clk);
    end
    cmd_ready = 1'b0;
    a_valid   = 1'b0;
    chk(done, "R10 transaction completes", done, 1);
    chk(a_ready === 1'b1 && cmd_valid === 1'b0, "R1 ready after last", a_ready, 1);
    chk(idx == exp_addr.size(), "R8 command count", idx, exp_addr.size());
    if (flip) chk(n_fail == fails_before, "R12 config change ignored", n_fail - fails_before, 0);
    txn_no++;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_fail++;
    $display("FAIL R10 watchdog expired: actual hung expected done");
    summary();
    $finish;
  end

  initial begin
    int lens_i[5] = '{0, 1, 2, 5, 15};
    int lens_f[3] = '{0, 1, 3};
    int lens_w[4] = '{1, 3, 7, 15};
    rst_n = 1'b0;
    a_valid = 1'b0; cmd_ready = 1'b0;
    a_addr = '0; a_len = '0; a_size = '0; a_burst = 2'd1;
    cfg_half_width = 1'b0; cfg_bl8 = 1'b0;
    repeat (3) @(negedge clk);
    chk(a_ready === 1'b1 && cmd_valid === 1'b0, "R11 in reset", {a_ready, cmd_valid}, 2);
    rst_n = 1'b1;
    @(negedge clk);
    chk(a_ready === 1'b1 && cmd_valid === 1'b0, "R11 after reset", {a_ready, cmd_valid}, 2);

    for (int cfg = 0; cfg < 4; cfg++) begin
      bit h = cfg[0];
      bit b = cfg[1];
      for (int s = 0; s < 4; s++) begin
        foreach (lens_i[li])
          for (int off = 0; off < 16; off++)
            run_txn(longint'('h1000 + off), lens_i[li], s, 1, h, b);
        foreach (lens_f[lf])
          for (int off = 0; off < 16; off++)
            run_txn(longint'('h3000 + off), lens_f[lf], s, 0, h, b);
        foreach (lens_w[lw])
          for (int k = 0; k <= lens_w[lw]; k++)
            run_txn(longint'('h5000) + (longint'(k) << s), lens_w[lw], s, 2, h, b);
      end
      run_txn(longint'('h1000), 3, 2, 3, h, b);
      run_txn(longint'('h1005), 3, 2, 3, h, b);
    end
    summary();
    $finish;
  end
endmodule